// File: doc/BRIEF.md
# DDR Read Capture with Half-Rate Word Assembly

This block is the read-path register chain of one data pin. A double-data-rate serial bit on `din` is sampled on both edges of a capture strobe. The two bits are passed into a zero-phase resynchronisation clock domain. There they are packed, two pairs at a time, into a four-bit word that changes at half the resync rate.

The half rate is set by a divide-by-two phase machine clocked by the resync clock. Its phase is driven out both as a half-rate clock for the core and on a chain port. Wide pin groups stay in one phase because a divider built as a slave copies its neighbour's chain output, not its own state.

A run-time select, `bypass_sel`, can be changed at any cycle. It chooses whether the core sees the assembled word or the raw pin value.

Build-time options are:
- strobe inversion, needed for strobes captured on the opposite polarity;
- removal of the resync register;
- master or slave role for the divider.

The divider phase machine has two states, `PH_LOW` and `PH_HIGH`. Reset forces `PH_LOW`. A master takes the transitions `PH_LOW -> PH_HIGH` and `PH_HIGH -> PH_LOW` on every resync edge. A slave takes `PH_LOW -> PH_HIGH` when its chain input is low and `PH_HIGH -> PH_LOW` when its chain input is high, and otherwise stays where it is.

Edge numbering used below: edge 0 is the first rising resync edge at which `rst` is sampled low. `r[j]` is the bit sampled on the strobe rise that coincides with edge j. `f[j]` is the bit sampled on the strobe fall between edges j and j+1. Bits from before reset release count as 0.

Top module: `ddr_halfrate_capture`

## Requirements
- R1: While `rst` is sampled high on rising resync edges, the divider holds `PH_LOW` (`half_clk` = 0, `chain_out` = 0) and the capture, resync and word registers are cleared, so `core_data` reads 0 when `bypass_sel` is low.
- R2: The word is laid out as bit 0 = rise bit of the older pair, bit 1 = fall bit of the older pair, bit 2 = rise bit of the newer pair, bit 3 = fall bit of the newer pair.
- R3: With the resync register in use, the word after odd edge k is {f[k-2], r[k-2], f[k-3], r[k-3]}.
- R4: The word changes only on edges taken in state `PH_HIGH` (odd k) and holds its value across edges taken in `PH_LOW` (even k).
- R5: A master divider enters `PH_HIGH` at edge 0 and changes state on every following edge, so `half_clk` = 1 after even k and 0 after odd k; `chain_out` equals `half_clk`.
- R6: A slave divider whose `chain_in` is driven by a master's `chain_out` shows the same `half_clk` as that master after every edge.
- R7: While `bypass_sel` is high, `core_data` = {3'b000, din} combinationally. The word keeps assembling underneath, so once `bypass_sel` drops, `core_data` shows the word R3 predicts.
- R8: With the resync register removed (`RESYNC_EN` = 0), the word after odd edge k is {f[k-1], r[k-1], f[k-2], r[k-2]}, one edge earlier than R3.
- R9: Asserting `rst` in mid-run and releasing it restarts the phase and the edge numbering from edge 0, with history cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_strobe | input | 1 | Capture strobe; both edges sample `din` |
| clk_resync | input | 1 | Zero-phase resync clock; all later stages use its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Double-data-rate pin data |
| bypass_sel | input | 1 | 1: core sees raw `din`; 0: core sees the assembled word |
| chain_in | input | 1 | Phase from the neighbouring master (used in slave role) |
| chain_out | output | 1 | This divider's phase, for the next divider in the chain |
| half_clk | output | 1 | Half-rate clock to the core (1 in `PH_HIGH`) |
| core_data | output | 4 | Word or bypassed pin value to the core |

## Verification
In the bench the strobe and the resync clock are the same 250 MHz signal. Each fall bit is driven 1 ns after a rise and each rise bit 1 ns before it, and every output is sampled 1 ns after each rising edge.

The timing of each result is as follows:
- `half_clk` and `chain_out` reflect edge k at once.
- The assembled word reflects pairs from three and two edges back with the resync register in use, and from two and one edge back without it.
- It is refreshed only after odd edges.
- The bypassed value follows `din` in the same sample.

A behavioural model keeps every driven bit in arrays indexed by edge. At each sample it builds the expected word from those indices and holds it across even edges. It compares against the master, slave and resync-less instances on every clock.

// File: rtl/ddrcap_pkg.sv
package ddrcap_pkg;
    // Divider phase machine states
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // One captured pair: rise bit in the low position
    typedef struct packed {
        logic fall_bit;
        logic rise_bit;
    } bit_pair_t;

    localparam int PAIRS_PER_WORD = 2;
    localparam int PAIR_W         = $bits(bit_pair_t);
    localparam int WORD_W         = PAIRS_PER_WORD * PAIR_W;
endpackage

// File: rtl/ddrcap_edge_capture.sv
module ddrcap_edge_capture
    import ddrcap_pkg::*;
#(
    parameter bit INVERT_STROBE = 1'b0
) (
    input  logic      clk_strobe,
    input  logic      rst,
    input  logic      din,
    output bit_pair_t cap_out
);
    logic strb;
    logic rise_q;
    logic fall_q;

    assign strb = clk_strobe ^ INVERT_STROBE;

    always_ff @(posedge strb) begin
        if (rst) rise_q <= 1'b0;
        else     rise_q <= din;
    end

    always_ff @(negedge strb) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= din;
    end

    assign cap_out.rise_bit = rise_q;
    assign cap_out.fall_bit = fall_q;

    AST_CAPTURE_CLEAR: assert property (@(posedge strb) rst |=> (rise_q == 1'b0)); // R1
endmodule

// File: rtl/ddrcap_resync.sv
module ddrcap_resync
    import ddrcap_pkg::*;
#(
    parameter bit RESYNC_EN = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  bit_pair_t cap_in,
    output bit_pair_t sync_out
);
    bit_pair_t sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= cap_in;
    end

    // Build-time choice: registered pair or capture flops passed straight through
    assign sync_out = RESYNC_EN ? sync_q : cap_in;

    AST_RESYNC_CLEAR: assert property (@(posedge clk) rst |=> (sync_q == '0)); // R1
endmodule

// File: rtl/ddrcap_half_divider.sv
module ddrcap_half_divider
    import ddrcap_pkg::*;
#(
    parameter bit IS_SLAVE = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   chain_in,
    output phase_e phase,
    output logic   half_clk,
    output logic   chain_out
);
    phase_e phase_q;
    phase_e phase_nxt;
    logic   follow_bit;

    // Slave copies the neighbour's phase; master steps from its own state
    assign follow_bit = IS_SLAVE ? chain_in : (phase_q == PH_HIGH);

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_LOW;
        else     phase_q <= phase_nxt;
    end

    always_comb begin
        phase_nxt = phase_q;
        unique case (phase_q)
            PH_LOW:  phase_nxt = follow_bit ? PH_LOW  : PH_HIGH;
            PH_HIGH: phase_nxt = follow_bit ? PH_LOW  : PH_HIGH;
        endcase
    end

    always_comb begin
        half_clk  = (phase_q == PH_HIGH);
        chain_out = (phase_q == PH_HIGH);
    end

    assign phase = phase_q;

    AST_RESET_PHASE: assert property (@(posedge clk) rst |=> (phase_q == PH_LOW)); // R1

    generate
        if (IS_SLAVE) begin : g_slave
            AST_SLAVE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (half_clk == !$past(chain_in))); // R6
        end else begin : g_master
            AST_MASTER_TOGGLE: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (half_clk != $past(half_clk))); // R5
        end
    endgenerate
endmodule

// File: rtl/ddrcap_word_demux.sv
module ddrcap_word_demux
    import ddrcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  bit_pair_t         sync_in,
    output logic [WORD_W-1:0] word
);
    bit_pair_t         prev_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            word_q <= '0;
        end else begin
            prev_q <= sync_in;
            if (phase == PH_HIGH) word_q <= {sync_in, prev_q};
        end
    end

    assign word = word_q;

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW) |=> $stable(word_q)); // R4
endmodule

// File: rtl/ddr_halfrate_capture.sv
module ddr_halfrate_capture
    import ddrcap_pkg::*;
#(
    parameter bit INVERT_STROBE = 1'b0,
    parameter bit RESYNC_EN     = 1'b1,
    parameter bit IS_SLAVE      = 1'b0
) (
    input  logic              clk_strobe,
    input  logic              clk_resync,
    input  logic              rst,
    input  logic              din,
    input  logic              bypass_sel,
    input  logic              chain_in,
    output logic              chain_out,
    output logic              half_clk,
    output logic [WORD_W-1:0] core_data
);
    bit_pair_t         cap_pair;
    bit_pair_t         sync_pair;
    phase_e            phase;
    logic [WORD_W-1:0] word;

    ddrcap_edge_capture #(.INVERT_STROBE(INVERT_STROBE)) u_capture (
        .clk_strobe (clk_strobe),
        .rst        (rst),
        .din        (din),
        .cap_out    (cap_pair)
    );

    ddrcap_resync #(.RESYNC_EN(RESYNC_EN)) u_resync (
        .clk      (clk_resync),
        .rst      (rst),
        .cap_in   (cap_pair),
        .sync_out (sync_pair)
    );

    ddrcap_half_divider #(.IS_SLAVE(IS_SLAVE)) u_divider (
        .clk       (clk_resync),
        .rst       (rst),
        .chain_in  (chain_in),
        .phase     (phase),
        .half_clk  (half_clk),
        .chain_out (chain_out)
    );

    ddrcap_word_demux u_demux (
        .clk     (clk_resync),
        .rst     (rst),
        .phase   (phase),
        .sync_in (sync_pair),
        .word    (word)
    );

    // Run-time output select
    always_comb begin
        if (bypass_sel) core_data = {{(WORD_W-1){1'b0}}, din};
        else            core_data = word;
    end

    AST_BYPASS_UPPER_ZERO: assert property (@(posedge clk_resync) disable iff (rst)
        bypass_sel |-> (core_data[WORD_W-1:1] == '0)); // R7
endmodule

// File: tb/ddr_halfrate_capture_bench.sv
`timescale 1ns/1ps
module ddr_halfrate_capture_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic       bypass_sel = 1'b0;
    logic       m_chain, m_half, s_chain, s_half, f_chain, f_half;
    logic [3:0] m_data, s_data, f_data;

    int checks = 0;
    int failures = 0;

    localparam int OFS = 4;
    logic dr [0:511];
    logic df [0:511];

    always #2 clk = ~clk;

    ddr_halfrate_capture u_ddr_halfrate_capture (
        .clk_strobe(clk), .clk_resync(clk), .rst(rst), .din(din),
        .bypass_sel(bypass_sel), .chain_in(1'b0), .chain_out(m_chain),
        .half_clk(m_half), .core_data(m_data));

    ddr_halfrate_capture #(.IS_SLAVE(1'b1)) u_slave (
        .clk_strobe(clk), .clk_resync(clk), .rst(rst), .din(din),
        .bypass_sel(1'b0), .chain_in(m_chain), .chain_out(s_chain),
        .half_clk(s_half), .core_data(s_data));

    ddr_halfrate_capture #(.RESYNC_EN(1'b0)) u_fast (
        .clk_strobe(clk), .clk_resync(clk), .rst(rst), .din(din),
        .bypass_sel(1'b0), .chain_in(1'b0), .chain_out(f_chain),
        .half_clk(f_half), .core_data(f_data));

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic gr(input int j);
        return (j < 0) ? 1'b0 : dr[j + OFS];
    endfunction

    function automatic logic gf(input int j);
        return (j < 0) ? 1'b0 : df[j + OFS];
    endfunction

    function automatic logic gen(input int pat, input int k, input bit is_fall);
        case (pat)
            0:       return 1'($urandom % 2);
            1:       return !is_fall;
            default: return ((k * 3 + int'(is_fall)) % 5) == 0;
        endcase
    endfunction

    task automatic run_seg(input int n, input int pat, input bit use_byp);
        logic [3:0] exp_word = 4'h0;
        logic [3:0] exp_fast = 4'h0;
        rst = 1'b1; din = 1'b0; bypass_sel = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 half_clk in reset", {3'b0, m_half}, 4'h0);
        chk("R1 chain_out in reset", {3'b0, m_chain}, 4'h0);
        chk("R1 word in reset", m_data, 4'h0);
        chk("R1 fast word in reset", f_data, 4'h0);
        chk("R9 slave phase in reset", {3'b0, s_half}, 4'h0);
        for (int j = 0; j < 512; j++) begin dr[j] = 1'b0; df[j] = 1'b0; end
        rst = 1'b0;
        din = 1'b0;   // fall bit f[-1]
        #2;
        din = 1'b0;   // rise bit r[0]
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            if (k % 2 == 1) begin
                exp_word = {gf(k-2), gr(k-2), gf(k-3), gr(k-3)};
                exp_fast = {gf(k-1), gr(k-1), gf(k-2), gr(k-2)};
            end
            chk("R5 master half_clk", {3'b0, m_half}, {3'b0, (k % 2 == 0)});
            chk("R5 chain_out", {3'b0, m_chain}, {3'b0, m_half});
            chk("R6 slave half_clk", {3'b0, s_half}, {3'b0, m_half});
            if (bypass_sel)
                chk("R7 bypass pin value", m_data, {3'b0, gr(k)});
            else
                chk("R3 R4 R2 word", m_data, exp_word);
            chk("R8 no-resync word", f_data, exp_fast);
            bypass_sel = use_byp && ((k % 7) >= 3);
            df[k + OFS] = gen(pat, k, 1'b1);
            din = df[k + OFS];
            #2;
            dr[k + 1 + OFS] = gen(pat, k + 1, 1'b0);
            din = dr[k + 1 + OFS];
        end
    endtask

    initial begin
        #800000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        run_seg(60, 1, 1'b0);   // alternating pattern
        run_seg(120, 0, 1'b1);  // random with run-time bypass toggling
        run_seg(61, 2, 1'b0);   // R9: reset after odd-length segment, sparse pattern
        run_seg(40, 0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule